// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter with Parallel Distributed Arithmetic

This block is the last stage of a multistage receive decimator. It accepts one signed sample per clock, qualified by a valid strobe, and halves the rate with an 11-tap half-band FIR filter. It delivers one filtered result for every second accepted sample. The two taps at offsets 2 and 4 on each side of the centre are zero, so only the centre tap and the three odd-offset symmetric pairs take part. Sample pairs that share a coefficient are added before the products are formed.

No multipliers are used. Each bit position of the four pre-added operands forms a 4-bit address into a small coefficient-sum table. Every bit position has its own copy of that table, so all bit planes are resolved in the same clock. The weighted plane results are summed in a registered binary adder tree. The filter therefore accepts a new sample on every clock, with no stall.

A two-state phase machine tracks pairing. In `PH_FIRST` it waits for the first sample of a pair. Accepting a sample there moves it to `PH_SECOND`. Accepting a sample in `PH_SECOND` returns it to `PH_FIRST` and launches a result into the pipeline. A clock with no valid input leaves the state as it is.

Top module: `hb_da_decim`

## Requirements
- R1: While reset is held and in the first cycle after reset, `out_valid` is 0 and `out_data` is 0. Reset also clears the sample history to zero and sets the phase machine to `PH_FIRST`.
- R2: Exactly one result is produced for each pair of accepted samples. A result is produced on the 2nd, 4th, 6th, ... accepted sample after reset, and never in two consecutive cycles.
- R3: Let x0 be the sample just accepted and xk the sample accepted k samples earlier, with zeros before reset. The result is exactly 4*(x0+x10) - 12*(x2+x8) + 40*(x4+x6) + 64*x5, at full precision and with no rounding.
- R4: `out_valid` rises on the sixth rising edge after the edge that accepted the pair-completing sample.
- R5: A cycle with `in_valid` low neither shifts the history nor changes the phase.
- R6: Full-scale inputs of -2048 and +2047 (12-bit two's complement) give exact results, so the sign-bit plane is weighted negatively. No result exceeds 176*2048 in magnitude.
- R7: `out_valid` is a one-cycle pulse. `out_data` holds the last result until the next pulse.
- R8: Valid samples on every clock, with no idle gaps, are all accepted, and each pair gives a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | DW (12) | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe at half the input rate |
| out_data | output | DW+10 (22) | Signed full-precision filtered result |

## Verification
The bench drives an impulse so that each coefficient shows up in the decimated output at a known position. A swapped pair or a wrong table entry therefore gives a visibly wrong tap value. Long runs at +2047 and -2048, and alternating extremes, target the sign-bit plane. A design that added that plane instead of subtracting it would be off by a large multiple of the coefficient sums.

Gapped valid patterns check that idle cycles do not advance the history or the pair phase. If they did, results would come from the wrong samples or on the wrong input. A back-to-back segment and constrained-random traffic check the exact six-edge latency, the one-cycle pulse width and that `out_data` holds between strobes. An off-by-one in the pipeline or the valid chain shows up as a strobe one cycle early or late.

// File: rtl/hbdec_pkg.sv
package hbdec_pkg;

    // Fixed half-band coefficients (centre and odd offsets from centre)
    localparam int C_CTR  = 64;
    localparam int C_OFF1 = 40;
    localparam int C_OFF3 = -12;
    localparam int C_OFF5 = 4;

    localparam int N_TAPS = 11;
    localparam int N_DA   = 4;   // DA operands: three symmetric pairs + centre

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    localparam int CSUM = iabs(C_CTR) + 2 * (iabs(C_OFF1) + iabs(C_OFF3) + iabs(C_OFF5));

    // Address bit 0: offset-5 pair, bit 1: offset-3 pair,
    // bit 2: offset-1 pair, bit 3: centre sample
    function automatic int da_entry(input logic [N_DA-1:0] a);
        int r;
        r = 0;
        if (a[0]) r += C_OFF5;
        if (a[1]) r += C_OFF3;
        if (a[2]) r += C_OFF1;
        if (a[3]) r += C_CTR;
        return r;
    endfunction

    typedef enum logic [0:0] {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

endpackage

// File: rtl/hbdec_tapline.sv
module hbdec_tapline
    import hbdec_pkg::*;
#(
    parameter int DW = 12,
    localparam int PW = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 pair_done,
    output logic                 pre_valid,
    output logic signed [PW-1:0] pre_word [N_DA]
);

    logic signed [DW-1:0] tap_q [N_TAPS];
    phase_e ph_q, ph_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_FIRST;
        else     ph_q <= ph_d;
    end

    // Next state
    always_comb begin
        ph_d = ph_q;
        if (in_valid) begin
            unique case (ph_q)
                PH_FIRST:  ph_d = PH_SECOND;
                PH_SECOND: ph_d = PH_FIRST;
            endcase
        end
    end

    // History and pair launch
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_done <= 1'b0;
            for (int i = 0; i < N_TAPS; i++) tap_q[i] <= '0;
        end else begin
            pair_done <= in_valid && (ph_q == PH_SECOND);
            if (in_valid) begin
                tap_q[0] <= in_data;
                for (int i = 1; i < N_TAPS; i++) tap_q[i] <= tap_q[i-1];
            end
        end
    end

    function automatic logic signed [PW-1:0] sx(input logic signed [DW-1:0] v);
        return {v[DW-1], v};
    endfunction

    // Symmetric pre-add stage
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_valid <= 1'b0;
            for (int k = 0; k < N_DA; k++) pre_word[k] <= '0;
        end else begin
            pre_valid   <= pair_done;
            pre_word[0] <= sx(tap_q[0]) + sx(tap_q[10]);
            pre_word[1] <= sx(tap_q[2]) + sx(tap_q[8]);
            pre_word[2] <= sx(tap_q[4]) + sx(tap_q[6]);
            pre_word[3] <= sx(tap_q[5]);
        end
    end

    p_no_adjacent_r2: assert property (@(posedge clk) disable iff (rst)
        pair_done |=> !pair_done);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(ph_q) && !pair_done));

endmodule

// File: rtl/hbdec_da_planes.sv
module hbdec_da_planes
    import hbdec_pkg::*;
#(
    parameter int PW = 13,
    parameter int AW = 22,
    parameter int NL = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pre_valid,
    input  logic signed [PW-1:0] pre_word [N_DA],
    output logic                 term_valid,
    output logic signed [AW-1:0] term [NL]
);

    always_ff @(posedge clk) begin
        if (rst) term_valid <= 1'b0;
        else     term_valid <= pre_valid;
    end

    for (genvar b = 0; b < NL; b++) begin : g_plane
        if (b < PW) begin : g_live
            logic [N_DA-1:0]      addr;
            logic signed [AW-1:0] ev;

            always_comb begin
                for (int k = 0; k < N_DA; k++) addr[k] = pre_word[k][b];
                ev = AW'(da_entry(addr));
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    term[b] <= '0;
                end else if (b == PW - 1) begin
                    term[b] <= -(ev <<< b);   // sign-bit plane carries negative weight
                end else begin
                    term[b] <= ev <<< b;
                end
            end
        end else begin : g_pad
            assign term[b] = '0;
        end
    end

endmodule

// File: rtl/hbdec_addtree.sv
module hbdec_addtree #(
    parameter int AW = 22,
    parameter int NL = 16,
    localparam int LVL = $clog2(NL)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 leaf_valid,
    input  logic signed [AW-1:0] leaf [NL],
    output logic                 root_valid,
    output logic signed [AW-1:0] root
);

    logic [LVL-2:0]       vpipe;
    logic signed [AW-1:0] sum_q [NL-1];
    logic signed [AW-1:0] node  [2*NL-1];

    // Heap view: internal nodes first, then leaves
    always_comb begin
        for (int i = 0; i < 2 * NL - 1; i++) begin
            if (i < NL - 1) node[i] = sum_q[i];
            else            node[i] = leaf[i - (NL - 1)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe <= '0;
            for (int i = 0; i < NL - 1; i++) sum_q[i] <= '0;
        end else begin
            vpipe <= {vpipe, leaf_valid} & {LVL-1{1'b1}};
            for (int i = 1; i < NL - 1; i++) sum_q[i] <= node[2*i+1] + node[2*i+2];
            if (vpipe[LVL-2]) sum_q[0] <= node[1] + node[2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) root_valid <= 1'b0;
        else     root_valid <= vpipe[LVL-2];
    end

    assign root = sum_q[0];

endmodule

// File: rtl/hb_da_decim.sv
module hb_da_decim
    import hbdec_pkg::*;
#(
    parameter int DW = 12,
    localparam int PW = DW + 1,
    localparam int AW = PW + $clog2(CSUM) + 1,
    localparam int NL = 2 ** $clog2(PW)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [AW-1:0] out_data
);

    localparam int MAXY = CSUM * (2 ** (DW - 1));

    logic                 pair_done;
    logic                 pre_valid;
    logic signed [PW-1:0] pre_word [N_DA];
    logic                 term_valid;
    logic signed [AW-1:0] term [NL];

    hbdec_tapline #(.DW(DW)) u_tapline (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .pair_done (pair_done),
        .pre_valid (pre_valid),
        .pre_word  (pre_word)
    );

    hbdec_da_planes #(.PW(PW), .AW(AW), .NL(NL)) u_planes (
        .clk        (clk),
        .rst        (rst),
        .pre_valid  (pre_valid),
        .pre_word   (pre_word),
        .term_valid (term_valid),
        .term       (term)
    );

    hbdec_addtree #(.AW(AW), .NL(NL)) u_tree (
        .clk        (clk),
        .rst        (rst),
        .leaf_valid (term_valid),
        .leaf       (term),
        .root_valid (out_valid),
        .root       (out_data)
    );

    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        pair_done |-> ##6 out_valid);

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    p_range_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data <= MAXY) && (out_data >= -MAXY)));

endmodule

// File: tb/hb_da_decim_tb.sv
`timescale 1ns/1ps
module hb_da_decim_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [11:0] in_data = '0;
    logic               out_valid;
    logic signed [21:0] out_data;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    int  hist [11];
    bit  ph;
    bit  mv [8];
    int  md [8];
    int  last_y;

    always #4 clk = ~clk;

    hb_da_decim u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R3 reference
    function automatic int model_y();
        return 4 * (hist[0] + hist[10]) - 12 * (hist[2] + hist[8])
             + 40 * (hist[4] + hist[6]) + 64 * hist[5];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 11; i++) hist[i] = 0;
        for (int i = 0; i < 8; i++) begin mv[i] = 0; md[i] = 0; end
        ph = 0;
        last_y = 0;
    endtask

    // One clock: check outputs after the last edge, then drive the next input
    task automatic cyc(input bit v, input int d, input string tag);
        @(negedge clk);
        for (int i = 7; i > 0; i--) begin mv[i] = mv[i-1]; md[i] = md[i-1]; end
        mv[0] = 0;
        chk(out_valid == mv[7], "R2 R4 valid", int'(out_valid), int'(mv[7]));
        if (mv[7]) begin
            chk(int'(out_data) == md[7], tag, int'(out_data), md[7]);
            last_y = md[7];
        end else begin
            chk(int'(out_data) == last_y, "R7 hold", int'(out_data), last_y);
        end
        in_valid = v;
        in_data  = 12'(d);
        if (v) begin
            for (int i = 10; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = d;
            if (ph) begin mv[0] = 1; md[0] = model_y(); end
            ph = !ph;
        end
    endtask

    function automatic int rnd_s12();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    initial begin
        void'($urandom(32'd24681));
        model_clear();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(out_data == '0, "R1 data in reset", int'(out_data), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(out_data == '0, "R1 data after reset", int'(out_data), 0);

        // R3 impulse: decimated response exposes each coefficient
        cyc(1, 1, "R3 impulse");
        for (int i = 0; i < 14; i++) cyc(1, 0, "R3 impulse");

        // R8 back-to-back random
        for (int i = 0; i < 60; i++) cyc(1, rnd_s12(), "R8 back-to-back");

        // R6 extremes
        for (int i = 0; i < 16; i++) cyc(1, 2047, "R6 max");
        for (int i = 0; i < 16; i++) cyc(1, -2048, "R6 min");
        for (int i = 0; i < 24; i++) cyc(1, (i % 2) ? -2048 : 2047, "R6 alt");
        for (int i = 0; i < 24; i++) cyc(1, ((i / 2) % 2) ? -2048 : 2047, "R6 alt2");

        // R5 gaps: idle cycles scattered, with garbage data while invalid
        for (int i = 0; i < 60; i++) begin
            cyc(1, rnd_s12(), "R5 gaps");
            for (int g = 0; g < (i % 4); g++) cyc(0, rnd_s12(), "R5 gaps");
        end

        // R3 constrained random traffic
        for (int i = 0; i < 1500; i++)
            cyc(($urandom_range(0, 9) < 6), rnd_s12(), "R3 random");

        // drain
        for (int i = 0; i < 10; i++) cyc(0, 0, "R3 drain");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule